// File: doc/BRIEF.md
# Standby Wake Sequencer with Real-Time Clock

This block lets a processing subsystem sleep through quiet periods without losing track of time. A free-running scaler, fed by the master clock, stays active in every state. It produces a 100 Hz tick, and after a fixed number of those ticks it also produces a slow wake tick, which is every 1.28 s at the default settings. A real-time-clock counter, kept in 10 ms units, follows the 100 Hz tick while the subsystem is awake.

When the standby-allowed switch is set, the sequencer drops the power-enable output and ignores the 100 Hz tick. It stays that way until the next wake tick. At that wake tick it raises power again and adds the full wake interval to the clock in one step. It then runs a short service window, and at the end of that window it samples the switch once. If the switch is still set, the sequencer goes back to sleep. Otherwise it resumes normal running. The scaler ratios are parameters, so a simulation can use short periods. The default of 20480 master cycles per tick matches a 2.048 MHz master clock.

Top module: `swk_standby_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, rtc_o is 0, state_o is RUN (0) and power_en_o is 1. After reset the first tick_o pulse appears TICK_DIV-1 clock edges after release.
- R2: tick_o is high for exactly one cycle in every TICK_DIV cycles. wake_tick_o is high only together with tick_o, once in every WAKE_TICKS ticks. The scaler keeps running in every state.
- R3: In RUN (0) and SERVICE (2), each cycle with tick_o high adds 1 to rtc_o at the next clock edge.
- R4: In RUN, a cycle with standby_allow_i high moves state_o to SLEEP (1) at the next edge and clears power_en_o. A tick in that same cycle is still counted.
- R5: In SLEEP, tick_o pulses without wake_tick_o leave rtc_o unchanged. Changes of standby_allow_i have no effect, and the block stays in SLEEP.
- R6: A wake_tick_o cycle in SLEEP adds WAKE_TICKS to rtc_o in a single step. It moves state_o to SERVICE (2) and sets power_en_o at the same edge.
- R7: SERVICE lasts exactly SERVICE_CYC cycles. Only the value of standby_allow_i in the last of those cycles decides the next state: 1 selects SLEEP and 0 selects RUN.
- R8: rtc_o wraps from 2^RTC_W-1 to 0.
- R9: power_en_o is low exactly when state_o is SLEEP. The state encoding is RUN=0, SLEEP=1, SERVICE=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| standby_allow_i | input | 1 | Standby-allowed switch, synchronous to clk_i |
| power_en_o | output | 1 | Main power enable, low while asleep |
| rtc_o | output | RTC_W | Real-time clock in tick units |
| tick_o | output | 1 | One-cycle 100 Hz tick pulse |
| wake_tick_o | output | 1 | One-cycle wake tick pulse |
| state_o | output | 2 | Sequencer state (0 RUN, 1 SLEEP, 2 SERVICE) |

## Verification
The bench builds the block with TICK_DIV=8, WAKE_TICKS=4, SERVICE_CYC=3 and RTC_W=8. With these values a tick occurs every 8 cycles and a wake every 32 cycles. Several sleep and wake rounds, including a switch that changes during service and a sleep entry that lands on a tick, therefore fit into about a hundred cycles. The 8-bit clock also wraps after about 2000 cycles, which puts R8 within reach of a short run.

// File: rtl/swk_pkg.sv
package swk_pkg;
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_SLEEP   = 2'd1,
        ST_SERVICE = 2'd2
    } swk_state_e;
endpackage

// File: rtl/swk_scaler.sv
module swk_scaler #(
    parameter int TICK_DIV   = 20480,
    parameter int WAKE_TICKS = 128
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o,
    output logic wake_o
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int WW = (WAKE_TICKS > 1) ? $clog2(WAKE_TICKS) : 1;

    typedef struct packed {
        logic [PW-1:0] pre;
        logic [WW-1:0] wk;
    } scl_t;

    scl_t sc_d, sc_q;
    logic pre_last, wk_last;

    always_comb begin
        pre_last = (sc_q.pre == PW'(TICK_DIV - 1));
        wk_last  = (sc_q.wk == WW'(WAKE_TICKS - 1));
        sc_d     = sc_q;
        if (pre_last) begin
            sc_d.pre = '0;
            sc_d.wk  = wk_last ? '0 : sc_q.wk + 1'b1;
        end else begin
            sc_d.pre = sc_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) sc_q <= '0;
        else         sc_q <= sc_d;
    end

    assign tick_o = pre_last;
    assign wake_o = pre_last & wk_last;
endmodule

// File: rtl/swk_rtc.sv
module swk_rtc #(
    parameter int RTC_W = 32,
    parameter int STEP  = 128
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             inc_one_i,
    input  logic             inc_lump_i,
    output logic [RTC_W-1:0] rtc_o
);
    localparam logic [RTC_W-1:0] STEP_V = RTC_W'(STEP);

    typedef struct packed {
        logic [RTC_W-1:0] cnt;
    } rtc_t;

    rtc_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (inc_lump_i)     r_d.cnt = r_q.cnt + STEP_V;
        else if (inc_one_i) r_d.cnt = r_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign rtc_o = r_q.cnt;
endmodule

// File: rtl/swk_fsm.sv
module swk_fsm
    import swk_pkg::*;
#(
    parameter int SERVICE_CYC = 4
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_i,
    input  logic       wake_i,
    input  logic       allow_i,
    output swk_state_e state_o,
    output logic       power_o,
    output logic       inc_one_o,
    output logic       inc_lump_o
);
    localparam int CW = (SERVICE_CYC > 1) ? $clog2(SERVICE_CYC) : 1;

    typedef struct packed {
        swk_state_e    st;
        logic [CW-1:0] cnt;
        logic          pwr;
    } fsm_t;

    fsm_t f_d, f_q;

    always_comb begin
        f_d        = f_q;
        inc_one_o  = tick_i && (f_q.st != ST_SLEEP);
        inc_lump_o = wake_i && (f_q.st == ST_SLEEP);
        case (f_q.st)
            ST_RUN: begin
                if (allow_i) begin
                    f_d.st  = ST_SLEEP;
                    f_d.pwr = 1'b0;
                end
            end
            ST_SLEEP: begin
                if (wake_i) begin
                    f_d.st  = ST_SERVICE;
                    f_d.cnt = CW'(SERVICE_CYC - 1);
                    f_d.pwr = 1'b1;
                end
            end
            ST_SERVICE: begin
                if (f_q.cnt == '0) begin
                    f_d.st  = allow_i ? ST_SLEEP : ST_RUN;
                    f_d.pwr = !allow_i;
                end else begin
                    f_d.cnt = f_q.cnt - 1'b1;
                end
            end
            default: begin
                f_d.st  = ST_RUN;
                f_d.cnt = '0;
                f_d.pwr = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            f_q.st  <= ST_RUN;
            f_q.cnt <= '0;
            f_q.pwr <= 1'b1;
        end else begin
            f_q <= f_d;
        end
    end

    assign state_o = f_q.st;
    assign power_o = f_q.pwr;
endmodule

// File: rtl/swk_standby_seq.sv
module swk_standby_seq
    import swk_pkg::*;
#(
    parameter int TICK_DIV    = 20480,
    parameter int WAKE_TICKS  = 128,
    parameter int SERVICE_CYC = 4,
    parameter int RTC_W       = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             standby_allow_i,
    output logic             power_en_o,
    output logic [RTC_W-1:0] rtc_o,
    output logic             tick_o,
    output logic             wake_tick_o,
    output logic [1:0]       state_o
);
    logic       tick, wake, inc_one, inc_lump;
    swk_state_e state;

    swk_scaler #(
        .TICK_DIV  (TICK_DIV),
        .WAKE_TICKS(WAKE_TICKS)
    ) u_scaler (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .tick_o(tick),
        .wake_o(wake)
    );

    swk_fsm #(
        .SERVICE_CYC(SERVICE_CYC)
    ) u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick),
        .wake_i    (wake),
        .allow_i   (standby_allow_i),
        .state_o   (state),
        .power_o   (power_en_o),
        .inc_one_o (inc_one),
        .inc_lump_o(inc_lump)
    );

    swk_rtc #(
        .RTC_W(RTC_W),
        .STEP (WAKE_TICKS)
    ) u_rtc (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .inc_one_i (inc_one),
        .inc_lump_i(inc_lump),
        .rtc_o     (rtc_o)
    );

    assign tick_o      = tick;
    assign wake_tick_o = wake;
    assign state_o     = state;
endmodule

// File: rtl/swk_standby_chk.sv
module swk_standby_chk
    import swk_pkg::*;
#(
    parameter int TICK_DIV    = 20480,
    parameter int WAKE_TICKS  = 128,
    parameter int SERVICE_CYC = 4,
    parameter int RTC_W       = 32
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             standby_allow_i,
    input logic             power_en_o,
    input logic [RTC_W-1:0] rtc_o,
    input logic             tick_o,
    input logic             wake_tick_o,
    input logic [1:0]       state_o
);
    localparam logic [RTC_W-1:0] STEP_V = RTC_W'(WAKE_TICKS);
    localparam int SW = $clog2(SERVICE_CYC + 2);

    logic [SW-1:0] svc_len_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni)                     svc_len_q <= '0;
        else if (state_o == ST_SERVICE)  svc_len_q <= svc_len_q + 1'b1;
        else                             svc_len_q <= '0;
    end

    a_r2_wake_with_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_tick_o |-> tick_o);

    a_r3_tick_counts: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o != ST_SLEEP && tick_o) |=> rtc_o == RTC_W'($past(rtc_o) + 1'b1));

    a_r4_enter_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == ST_RUN && standby_allow_i) |=> state_o == ST_SLEEP);

    a_r5_sleep_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == ST_SLEEP && !wake_tick_o) |=> ($stable(rtc_o) && state_o == ST_SLEEP));

    a_r6_wake_lump: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == ST_SLEEP && wake_tick_o) |=>
            (rtc_o == RTC_W'($past(rtc_o) + STEP_V) && state_o == ST_SERVICE));

    a_r7_service_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == ST_SERVICE) |-> svc_len_q < SW'(SERVICE_CYC));

    a_r7_service_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == ST_SERVICE && svc_len_q == SW'(SERVICE_CYC - 1)) |=>
            state_o == ($past(standby_allow_i) ? ST_SLEEP : ST_RUN));

    a_r9_power_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
        power_en_o == (state_o != ST_SLEEP));
endmodule

bind swk_standby_seq swk_standby_chk #(
    .TICK_DIV   (TICK_DIV),
    .WAKE_TICKS (WAKE_TICKS),
    .SERVICE_CYC(SERVICE_CYC),
    .RTC_W      (RTC_W)
) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .standby_allow_i(standby_allow_i),
    .power_en_o     (power_en_o),
    .rtc_o          (rtc_o),
    .tick_o         (tick_o),
    .wake_tick_o    (wake_tick_o),
    .state_o        (state_o)
);

// File: tb/swk_standby_seq_tb.sv
module swk_standby_seq_tb;
    localparam int TB_TICK = 8;
    localparam int TB_WAKE = 4;
    localparam int TB_SVC  = 3;
    localparam int TB_RW   = 8;

    typedef struct packed {
        logic [31:0] cyc;
        logic        sw;
        logic [7:0]  rtc;
        logic [1:0]  st;
        logic        wk;
    } vec_t;

    // state: 0 RUN, 1 SLEEP, 2 SERVICE; totals are edges since reset release
    localparam vec_t VECS [16] = '{
        '{32'd20, 1'b0, 8'd2,  2'd0, 1'b0},  // t20  R3 ticks at 8,16
        '{32'd1,  1'b1, 8'd2,  2'd1, 1'b0},  // t21  R4 enter sleep
        '{32'd10, 1'b1, 8'd2,  2'd1, 1'b1},  // t31  R5 tick at 24 ignored, R2 wake visible
        '{32'd1,  1'b1, 8'd6,  2'd2, 1'b0},  // t32  R6 lump +4
        '{32'd2,  1'b1, 8'd6,  2'd2, 1'b0},  // t34  R7 still servicing
        '{32'd1,  1'b1, 8'd6,  2'd1, 1'b0},  // t35  R7 switch set -> sleep
        '{32'd25, 1'b0, 8'd6,  2'd1, 1'b0},  // t60  R5 switch cleared while asleep, ignored
        '{32'd4,  1'b0, 8'd10, 2'd2, 1'b0},  // t64  R6 wake
        '{32'd3,  1'b0, 8'd10, 2'd0, 1'b0},  // t67  R7 switch clear -> run
        '{32'd13, 1'b0, 8'd12, 2'd0, 1'b0},  // t80  R3 ticks at 72,80
        '{32'd1,  1'b1, 8'd12, 2'd1, 1'b0},  // t81  R4
        '{32'd15, 1'b1, 8'd16, 2'd2, 1'b0},  // t96  R6 wake
        '{32'd2,  1'b1, 8'd16, 2'd2, 1'b0},  // t98  R7 switch set early in service
        '{32'd1,  1'b0, 8'd16, 2'd0, 1'b0},  // t99  R7 only last cycle counts
        '{32'd4,  1'b0, 8'd16, 2'd0, 1'b0},  // t103 R2 tick high
        '{32'd1,  1'b1, 8'd17, 2'd1, 1'b0}   // t104 R4 tick on sleep entry counted
    };

    logic             clk;
    logic             rst_n;
    logic             sw;
    logic             power_en;
    logic [TB_RW-1:0] rtc;
    logic             tick;
    logic             wake;
    logic [1:0]       state;

    int checks = 0;
    int errors = 0;
    int total  = 0;

    swk_standby_seq #(
        .TICK_DIV   (TB_TICK),
        .WAKE_TICKS (TB_WAKE),
        .SERVICE_CYC(TB_SVC),
        .RTC_W      (TB_RW)
    ) u_dut (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .standby_allow_i(sw),
        .power_en_o     (power_en),
        .rtc_o          (rtc),
        .tick_o         (tick),
        .wake_tick_o    (wake),
        .state_o        (state)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at t=%0d: actual %0d expected %0d", req, total, act, exp);
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
        total += n;
    endtask

    task automatic chk_all(input logic [7:0] e_rtc, input logic [1:0] e_st);
        chk("R3/R5/R6/R8 rtc", 32'(rtc), 32'(e_rtc));
        chk("R4/R7 state", 32'(state), 32'(e_st));
        chk("R9 power", 32'(power_en), 32'(e_st != 2'd1));
        chk("R2 tick", 32'(tick), 32'((total % TB_TICK) == TB_TICK - 1));
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        sw    = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 rtc", 32'(rtc), 32'd0);
        chk("R1 state", 32'(state), 32'd0);
        chk("R1 power", 32'(power_en), 32'd1);
        chk("R1 tick", 32'(tick), 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < 16; i++) begin
            sw = VECS[i].sw;
            run(int'(VECS[i].cyc));
            chk_all(VECS[i].rtc, VECS[i].st);
            chk("R2 wake", 32'(wake), 32'(VECS[i].wk));
        end

        // R6/R7: next wake at 128, then back to run
        sw = 1'b0;
        run(24);
        chk_all(8'd21, 2'd2);
        run(3);
        chk_all(8'd21, 2'd0);

        // R8: wrap from 255 to 0
        run(2007 - total);
        chk_all(8'd255, 2'd0);
        run(1);
        chk_all(8'd0, 2'd0);

        // R1: reset in the middle of running
        run(20);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 rtc after reset", 32'(rtc), 32'd0);
        chk("R1 state after reset", 32'(state), 32'd0);
        rst_n = 1'b1;
        total = 0;
        run(TB_TICK - 2);
        chk("R1 no early tick", 32'(tick), 32'd0);
        run(1);
        chk("R1 first tick", 32'(tick), 32'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule